// File: doc/BRIEF.md
# NRZI Line Coder with Bit Stuffing

This block carries a serial bit stream over one wire without a separate clock line. The transmit half maps each bit onto a line level with the toggle-on-zero NRZI rule: a 0 flips the level and a 1 keeps it. A long run of ones would leave the line without edges, so after a set number of ones in a row the transmitter sends an extra 0 of its own. While that extra bit goes out it holds off its data source for one bit time through a valid/ready handshake, so no input bit is lost.

The receive half takes one line sample per bit time. It marks a sample as valid with a strobe. It turns level changes back into bits and drops each inserted 0. When a position that must hold an inserted 0 holds a 1 instead, it raises a one-cycle error flag. Each clock cycle is one bit time. The two halves are independent, so a system can loop them back to each other or join them through a channel. Clock recovery, frame delimiters and checksums are left to other blocks.

Top module: `nrzi_stuff_link`

## Requirements
- R1: While reset is high and on the first cycle after it, line_out is 1, line_vld is 0, in_ready is 1, out_valid is 0 and stuff_err is 0. Both halves start with a line level of 1 and a run count of zero.
- R2: A data bit of value 0 that is accepted on a clock edge (in_valid and in_ready both high) makes line_out the inverse of its previous level from that edge on, with line_vld high for that bit time.
- R3: An accepted data bit of value 1 leaves line_out unchanged, with line_vld high for that bit time.
- R4: After RUN_LEN (default 6) consecutive ones have gone out, in_ready is low for exactly one bit time. During that bit time the encoder sends an inserted 0, so line_out toggles and line_vld is high.
- R5: Any 0 clears the run count, whether it is a data 0 or an inserted 0. A run of 13 data ones therefore causes exactly two inserted bits.
- R6: On a cycle with in_ready high and in_valid low, no bit is sent: line_vld goes low and line_out holds its level.
- R7: For each valid line sample, the decoder compares the sample with the previous valid sample. The same level decodes as 1 and a change decodes as 0. The bit appears on out_bit with out_valid high on the cycle after the sample. A cycle with line_in_vld low produces no output.
- R8: The valid sample that follows RUN_LEN decoded ones in a row is dropped: out_valid stays low for it. If that sample is a level change, stuff_err stays low.
- R9: If the sample that must be an inserted 0 decodes as 1, stuff_err is high for one cycle and out_valid stays low. The run count restarts, so another RUN_LEN ones are then delivered before the next drop.
- R10: When line_out and line_vld are looped back into line_in and line_in_vld, out_bit reproduces every accepted input bit in order. No inserted bit is delivered and stuff_err is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a data bit |
| in_bit | input | 1 | Data bit offered by the source |
| in_ready | output | 1 | Encoder can take a bit this cycle; low while it sends an inserted 0 |
| line_out | output | 1 | Encoded line level |
| line_vld | output | 1 | A bit is on line_out this bit time |
| line_in | input | 1 | Line level sample for the decoder |
| line_in_vld | input | 1 | line_in holds a bit sample this cycle |
| out_valid | output | 1 | out_bit holds a decoded data bit |
| out_bit | output | 1 | Decoded data bit |
| stuff_err | output | 1 | One-cycle pulse: an expected inserted 0 decoded as 1 |

## Verification
The properties assume reset is synchronous and held for at least one edge, and that in_bit carries meaning only on cycles where in_valid is high. They place no limit on how the source toggles in_valid or how often valid samples arrive at the decoder. The bench changes all inputs half a cycle away from the active edge. It runs the loopback from an idle gap, through a full 8-bit value sweep with idle bit times mixed in, to long runs of ones. It then drives the decoder input directly to create wrong inserted bits and sample gaps that the encoder can never produce.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;

  // What the encoder puts on the line in a given bit time.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_DATA  = 2'd1,
    ACT_STUFF = 2'd2
  } tx_act_e;

  // Reset level of the line for both halves.
  localparam logic LINE_IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic line_out,
  output logic line_vld
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_q;
  logic          level_q;
  logic          vld_q;
  logic          stuff_due;
  tx_act_e       act;

  assign stuff_due = (run_q == RUN_MAX);
  assign in_ready  = !stuff_due;

  always_comb begin
    if (stuff_due)     act = ACT_STUFF;
    else if (in_valid) act = ACT_DATA;
    else               act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= LINE_IDLE_LEVEL;
      vld_q   <= 1'b0;
    end else begin
      unique case (act)
        ACT_STUFF: begin
          level_q <= ~level_q;
          run_q   <= '0;
          vld_q   <= 1'b1;
        end
        ACT_DATA: begin
          vld_q <= 1'b1;
          if (in_bit) begin
            run_q <= run_q + 1'b1;
          end else begin
            level_q <= ~level_q;
            run_q   <= '0;
          end
        end
        default: vld_q <= 1'b0;
      endcase
    end
  end

  assign line_out = level_q;
  assign line_vld = vld_q;

endmodule

// File: rtl/nrzi_destuff_rx.sv
module nrzi_destuff_rx
  import nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic line_in_vld,
  output logic out_valid,
  output logic out_bit,
  output logic stuff_err
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_q;
  logic          prev_q;
  logic          valid_q;
  logic          bit_q;
  logic          err_q;
  logic          hold_is_one;
  logic          drop_slot;

  assign hold_is_one = (line_in == prev_q);
  assign drop_slot   = (run_q == RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      prev_q  <= LINE_IDLE_LEVEL;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (line_in_vld) begin
        prev_q <= line_in;
        if (drop_slot) begin
          run_q <= '0;
          err_q <= hold_is_one;
        end else begin
          valid_q <= 1'b1;
          bit_q   <= hold_is_one;
          run_q   <= hold_is_one ? run_q + 1'b1 : '0;
        end
      end
    end
  end

  assign out_valid = valid_q;
  assign out_bit   = bit_q;
  assign stuff_err = err_q;

endmodule

// File: rtl/nrzi_stuff_link.sv
module nrzi_stuff_link #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic line_out,
  output logic line_vld,
  input  logic line_in,
  input  logic line_in_vld,
  output logic out_valid,
  output logic out_bit,
  output logic stuff_err
);

  nrzi_stuff_tx #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (in_ready),
    .line_out (line_out),
    .line_vld (line_vld)
  );

  nrzi_destuff_rx #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .line_in     (line_in),
    .line_in_vld (line_in_vld),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .stuff_err   (stuff_err)
  );

endmodule

// File: rtl/nrzi_stuff_link_chk.sv
module nrzi_stuff_link_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_bit,
  input logic in_ready,
  input logic line_out,
  input logic line_vld,
  input logic line_in_vld,
  input logic out_valid,
  input logic stuff_err
);

  // R2: an accepted 0 flips the line
  assert_zero_toggles_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_bit) |=> (line_vld && line_out != $past(line_out)));

  // R3: an accepted 1 holds the line
  assert_one_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_bit) |=> (line_vld && $stable(line_out)));

  // R4: a stall sends an edge and lasts one bit time
  assert_stall_sends_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (line_vld && line_out != $past(line_out)));

  assert_stall_single_R4: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  // R6: no offer means an empty bit time
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (!line_vld && $stable(line_out)));

  // R7: no sample means no output
  assert_no_sample_no_out_R7: assert property (@(posedge clk) disable iff (rst)
    !line_in_vld |=> (!out_valid && !stuff_err));

  // R9: an error slot never delivers a bit
  assert_err_no_data_R9: assert property (@(posedge clk) disable iff (rst)
    stuff_err |-> !out_valid);

endmodule

bind nrzi_stuff_link nrzi_stuff_link_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_bit      (in_bit),
  .in_ready    (in_ready),
  .line_out    (line_out),
  .line_vld    (line_vld),
  .line_in_vld (line_in_vld),
  .out_valid   (out_valid),
  .stuff_err   (stuff_err)
);

// File: tb/test_nrzi_stuff_link.sv
module test_nrzi_stuff_link;

  localparam int RUN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, line_out, line_vld, line_in, line_in_vld;
  logic out_valid, out_bit, stuff_err;

  logic inject = 1'b0, inj_lvl = 1'b1, inj_vld = 1'b0;
  assign line_in     = inject ? inj_lvl : line_out;
  assign line_in_vld = inject ? inj_vld : line_vld;

  nrzi_stuff_link #(.RUN_LEN(RUN)) i_nrzi_stuff_link (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .line_out(line_out), .line_vld(line_vld),
    .line_in(line_in), .line_in_vld(line_in_vld),
    .out_valid(out_valid), .out_bit(out_bit), .stuff_err(stuff_err)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, stuffs = 0, errs_seen = 0;
  logic m_lvl = 1'b1;
  logic exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One encoder bit time; expected line values follow the requirements.
  task automatic step(input logic v, input logic b, output bit acc);
    bit stf;
    logic ev;
    string tag;
    stf = (m_cnt == RUN);
    chk(in_ready == !stf, "R4 in_ready", in_ready, !stf);
    in_valid = v;
    in_bit   = b;
    acc = v && !stf;
    if (stf) begin
      m_lvl = ~m_lvl; m_cnt = 0; ev = 1'b1; stuffs++; tag = "R4 stuffed bit";
    end else if (v) begin
      ev = 1'b1;
      exp_q.push_back(b);
      if (b) begin m_cnt++; tag = "R3 one holds"; end
      else begin m_lvl = ~m_lvl; m_cnt = 0; tag = "R2 zero toggles"; end
    end else begin
      ev = 1'b0; tag = "R6 idle";
    end
    @(negedge clk);
    chk(line_vld == ev, {tag, " line_vld"}, line_vld, ev);
    chk(line_out == m_lvl, {tag, " line_out"}, line_out, m_lvl);
  endtask

  task automatic send_bit(input logic b);
    bit acc;
    do step(1'b1, b, acc); while (!acc);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; inject = 1'b0;
    @(negedge clk);
    chk(line_out == 1'b1 && line_vld == 1'b0 && in_ready == 1'b1, "R1 tx reset",
        {line_out, line_vld, in_ready}, 3'b101);
    chk(out_valid == 1'b0 && stuff_err == 1'b0, "R1 rx reset", {out_valid, stuff_err}, 0);
    @(negedge clk);
    rst = 1'b0; m_cnt = 0; m_lvl = 1'b1; exp_q.delete();
  endtask

  task automatic dstep(input logic vld, input logic lvl, input logic ev,
                       input logic eb, input logic ee, input string tag);
    inj_vld = vld; inj_lvl = lvl;
    @(negedge clk);
    chk(out_valid == ev, {tag, " out_valid"}, out_valid, ev);
    if (ev) chk(out_bit == eb, {tag, " out_bit"}, out_bit, eb);
    chk(stuff_err == ee, {tag, " stuff_err"}, stuff_err, ee);
  endtask

  // Loopback monitor: R10 order and R8 no false error.
  always @(negedge clk) begin
    logic e;
    if (!rst && !inject) begin
      if (stuff_err) errs_seen++;
      if (out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 extra bit", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(out_bit == e, "R10 loopback bit", out_bit, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit acc;
    do_reset();

    // R5: 13 ones give exactly two inserted bits
    stuffs = 0;
    for (int i = 0; i < 13; i++) send_bit(1'b1);
    repeat (3) step(1'b0, 1'b0, acc);
    chk(stuffs == 2, "R5 stuff count for 13 ones", stuffs, 2);

    // Sweep every byte, LSB first, with idle gaps
    for (int w = 0; w < 256; w++) begin
      for (int i = 0; i < 8; i++) send_bit(w[i]);
      if (w % 3 == 0) step(1'b0, 1'b0, acc);
    end
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    repeat (4) step(1'b0, 1'b0, acc);
    chk(exp_q.size() == 0, "R10 all bits delivered", exp_q.size(), 0);
    chk(errs_seen == 0, "R8 no error on correct stuffing", errs_seen, 0);

    // Direct decoder stimulus
    do_reset();
    inject = 1'b1; inj_vld = 1'b0; inj_lvl = 1'b1;
    for (int i = 0; i < RUN; i++) dstep(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7 hold is one");
    dstep(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9 bad stuff bit");
    dstep(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 no sample");
    for (int i = 0; i < RUN; i++) dstep(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9 run restarted");
    dstep(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 stuff bit dropped");
    dstep(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 change is zero");
    dstep(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7 hold after change");
    dstep(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 gap");

    summary();
    $finish;
  end

endmodule